// File: doc/BRIEF.md
# Pipelined Butterfly Processor-to-Bank Network

This block joins eight processor request ports to eight shared memory bank ports. It does this through a three-level network of 2x2 switches rather than a full crossbar. Each request carries a read/write flag, a word address and write data, and the network adds a source tag. The lowest three word-address bits choose the bank, so consecutive words fall on different banks. The rest of the address is handed to the bank as its row. At level k a switch steers a request by bit k of its bank index. Every port can therefore reach every bank, and every XOR-shaped permutation of port to bank passes with no loss.

The switch levels are combinational and end in one register stage that feeds the banks. When two requests want the same switch output, a per-switch round-robin bit picks the winner. The loser is dropped and its port sees a one-cycle nack, after which the processor must issue the request again. There is no queue inside the network. A read that wins comes back to its own port after a fixed three cycles. The reply travels a reverse network that is steered by the source tag.

Each bank is expected to behave as a RAM with a one-cycle read.

Top module: `mnet_top`

## Requirements
- R1: Any port can address any bank, and every accepted request appears at exactly one bank port in the cycle after it was presented.
- R2: The bank index is word-address bits [2:0]. The bank port raises its valid in the cycle after the request and shows the request's row (address bits [9:3]), write flag and write data.
- R3: A read that is accepted in cycle t is presented to its bank at t+1. The bank read data returns at t+2, and the port shows reply valid with that data at t+3.
- R4: Each request presented in a cycle produces either an ack or a nack, never both, in the next cycle. No ack or nack occurs in a cycle after no request.
- R5: When two requests contend for one switch output, including two reads of the same address, exactly one is acked and only the acked read produces a reply.
- R6: A per-switch round-robin bit flips on every conflict, so the same pair of ports conflicting on consecutive cycles is granted alternately, and no port waits without bound.
- R7: A write stores its data at the bank and never produces a reply. A later read of that address returns the written data.
- R8: Read data is returned only to the port that issued the read.
- R9: Under retry traffic, every request completes exactly once and every read returns the value of the most recent accepted write to that address.
- R10: While reset is held and directly after it, ack, nack, reply valid and bank valid are all low.
- R11: When port p requests bank p XOR c for a constant c and all eight ports request in the same cycle, all eight are acked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqVld | input | 8 | Request valid, one bit per port |
| reqWe | input | 8 | 1 = write, 0 = read, per port |
| reqAddr | input | 8x10 | Word address per port; bits [2:0] select the bank |
| reqWdata | input | 8x32 | Write data per port |
| reqAck | output | 8 | Request of previous cycle accepted |
| reqNack | output | 8 | Request of previous cycle rejected, reissue needed |
| rspVld | output | 8 | Read reply valid per port |
| rspData | output | 8x32 | Read reply data per port |
| bankVld | output | 8 | Access valid per bank |
| bankWe | output | 8 | Write flag per bank |
| bankRow | output | 8x7 | Row within the bank |
| bankWdata | output | 8x32 | Write data per bank |
| bankRdata | input | 8x32 | Bank read data, one cycle after bankVld |

## Verification
A wrong swap strobe or a corrupted switch priority bit shows up at the ports in the next cycle. It appears either as an ack on a request that never reached its bank or as a bank access whose row and data belong to another port. A fault in the tag or read-pending pipeline causes no trouble on the request side. It surfaces three cycles after the read was acked, as a reply on the wrong port, a missing reply or stale data. A priority bit that fails to flip appears as the same winner on two back-to-back conflicts.

// File: rtl/mnet_pkg.sv
package mnet_pkg;
  localparam int NPORTS = 8;
  localparam int LG     = $clog2(NPORTS);
  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;
  localparam int ROW_W  = ADDR_W - LG;

  typedef logic [LG-1:0] portId_t;

  // request payload carried through the forward network
  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    portId_t           tag;
  } reqBeat_t;

  // strobes from the arbiter to the datapath
  typedef struct packed {
    logic [LG-1:0][NPORTS-1:0] swap;     // line takes its partner's beat at level k
    logic [NPORTS-1:0]         lineVld;  // surviving request per bank line
  } netStrobe_t;
endpackage

// File: rtl/mnet_ctl.sv
module mnet_ctl
  import mnet_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORTS-1:0]         reqVld,
  input  logic [NPORTS-1:0][LG-1:0] reqBank,
  output netStrobe_t                strobe,
  output logic [NPORTS-1:0]         ackQ,
  output logic [NPORTS-1:0]         nackQ
);
  logic [LG-1:0][NPORTS-1:0]   rrQ, rrNext;
  logic [LG:0][NPORTS-1:0]     lv;
  logic [LG:0][NPORTS-1:0][LG-1:0] dst;
  logic [LG:0][NPORTS-1:0][LG-1:0] src;
  logic [NPORTS-1:0]           grant;

  always_comb begin
    int   hi;
    logic aBit, bBit, conflict, winA, winB;
    hi = 0; aBit = 1'b0; bBit = 1'b0; conflict = 1'b0; winA = 1'b0; winB = 1'b0;
    lv[0]  = reqVld;
    dst[0] = reqBank;
    for (int p = 0; p < NPORTS; p++) src[0][p] = LG'(p);
    strobe = '0;
    rrNext = rrQ;
    grant  = '0;
    for (int k = 0; k < LG; k++) begin
      lv[k+1]  = '0;
      dst[k+1] = dst[k];
      src[k+1] = src[k];
      for (int i = 0; i < NPORTS; i++) begin
        if (((i >> k) & 1) == 0) begin
          hi       = i | (1 << k);
          aBit     = dst[k][i][k];
          bBit     = dst[k][hi][k];
          conflict = lv[k][i] && lv[k][hi] && (aBit == bBit);
          winA     = lv[k][i]  && !(conflict && rrQ[k][i]);
          winB     = lv[k][hi] && !(conflict && !rrQ[k][i]);
          // output with routing bit 0
          if (winA && !aBit) begin
            lv[k+1][i] = 1'b1;
          end else if (winB && !bBit) begin
            lv[k+1][i]         = 1'b1;
            strobe.swap[k][i]  = 1'b1;
            dst[k+1][i]        = dst[k][hi];
            src[k+1][i]        = src[k][hi];
          end
          // output with routing bit 1
          if (winB && bBit) begin
            lv[k+1][hi] = 1'b1;
          end else if (winA && aBit) begin
            lv[k+1][hi]        = 1'b1;
            strobe.swap[k][hi] = 1'b1;
            dst[k+1][hi]       = dst[k][i];
            src[k+1][hi]       = src[k][i];
          end
          if (conflict) rrNext[k][i] = winA;
        end
      end
    end
    strobe.lineVld = lv[LG];
    for (int b = 0; b < NPORTS; b++)
      if (lv[LG][b]) grant[src[LG][b]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackQ  <= '0;
      nackQ <= '0;
      rrQ   <= '0;
    end else begin
      ackQ  <= grant;
      nackQ <= reqVld & ~grant;
      rrQ   <= rrNext;
    end
  end

  // R4
  ack_nack_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((ackQ | nackQ) == $past(reqVld)) && ((ackQ & nackQ) == '0)));
endmodule

// File: rtl/mnet_dp.sv
module mnet_dp
  import mnet_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  netStrobe_t                    strobe,
  input  logic [NPORTS-1:0]             reqWe,
  input  logic [NPORTS-1:0][ADDR_W-1:0] reqAddr,
  input  logic [NPORTS-1:0][DATA_W-1:0] reqWdata,
  input  logic [NPORTS-1:0][DATA_W-1:0] bankRdata,
  output logic [NPORTS-1:0]             bankVld,
  output logic [NPORTS-1:0]             bankWe,
  output logic [NPORTS-1:0][ROW_W-1:0]  bankRow,
  output logic [NPORTS-1:0][DATA_W-1:0] bankWdata,
  output logic [NPORTS-1:0]             rspVld,
  output logic [NPORTS-1:0][DATA_W-1:0] rspData
);
  reqBeat_t [NPORTS-1:0] fwd [LG+1];
  reqBeat_t [NPORTS-1:0] beatQ;
  logic     [NPORTS-1:0] vldQ, rdPendQ, bankRdMask;
  portId_t  [NPORTS-1:0] rdTagQ;

  // forward levels: each line keeps its beat or takes its partner's
  always_comb begin
    for (int p = 0; p < NPORTS; p++)
      fwd[0][p] = '{we: reqWe[p], addr: reqAddr[p], wdata: reqWdata[p], tag: LG'(p)};
    for (int k = 0; k < LG; k++)
      for (int i = 0; i < NPORTS; i++)
        fwd[k+1][i] = strobe.swap[k][i] ? fwd[k][i ^ (1 << k)] : fwd[k][i];
  end

  always_ff @(posedge clk) begin
    beatQ  <= fwd[LG];
    rdTagQ <= rdTagQ;
    for (int b = 0; b < NPORTS; b++) rdTagQ[b] <= beatQ[b].tag;
    if (rst) begin
      vldQ    <= '0;
      rdPendQ <= '0;
    end else begin
      vldQ    <= strobe.lineVld;
      rdPendQ <= bankRdMask;
    end
  end

  always_comb begin
    for (int b = 0; b < NPORTS; b++) begin
      bankWe[b]     = beatQ[b].we;
      bankRow[b]    = beatQ[b].addr[ADDR_W-1:LG];
      bankWdata[b]  = beatQ[b].wdata;
      bankRdMask[b] = vldQ[b] && !beatQ[b].we;
    end
    bankVld = vldQ;
  end

  // reverse levels, steered by the source tag, undoing the top level first
  logic    [NPORTS-1:0]             rv [LG+1];
  portId_t [NPORTS-1:0]             rt [LG+1];
  logic    [NPORTS-1:0][DATA_W-1:0] rd [LG+1];
  logic    [LG-1:0][NPORTS-1:0]     collide;

  always_comb begin
    int   pi;
    logic ownBit, keepOwn, takeOther;
    pi = 0; ownBit = 1'b0; keepOwn = 1'b0; takeOther = 1'b0;
    rv[LG]  = rdPendQ;
    rt[LG]  = rdTagQ;
    rd[LG]  = bankRdata;
    collide = '0;
    for (int k = LG - 1; k >= 0; k--) begin
      for (int i = 0; i < NPORTS; i++) begin
        pi        = i ^ (1 << k);
        ownBit    = 1'(((i >> k) & 1));
        keepOwn   = rv[k+1][i]  && (rt[k+1][i][k]  == ownBit);
        takeOther = rv[k+1][pi] && (rt[k+1][pi][k] == ownBit);
        rv[k][i]      = keepOwn || takeOther;
        rt[k][i]      = takeOther ? rt[k+1][pi] : rt[k+1][i];
        rd[k][i]      = takeOther ? rd[k+1][pi] : rd[k+1][i];
        collide[k][i] = keepOwn && takeOther;
      end
    end
  end

  always_ff @(posedge clk) begin
    rspData <= rd[0];
    if (rst) rspVld <= '0;
    else     rspVld <= rv[0];
  end

  // R2
  for (genvar b = 0; b < NPORTS; b++) begin : g_route
    route_chk: assert property (@(posedge clk) disable iff (rst)
      vldQ[b] |-> (beatQ[b].addr[LG-1:0] == LG'(b)));
  end

  // R8
  ret_clash_chk: assert property (@(posedge clk) disable iff (rst) collide == '0);

  // R3
  rsp_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(rspVld) == $past($countones(bankRdMask), 2));
endmodule

// File: rtl/mnet_top.sv
module mnet_top
  import mnet_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NPORTS-1:0]             reqVld,
  input  logic [NPORTS-1:0]             reqWe,
  input  logic [NPORTS-1:0][ADDR_W-1:0] reqAddr,
  input  logic [NPORTS-1:0][DATA_W-1:0] reqWdata,
  output logic [NPORTS-1:0]             reqAck,
  output logic [NPORTS-1:0]             reqNack,
  output logic [NPORTS-1:0]             rspVld,
  output logic [NPORTS-1:0][DATA_W-1:0] rspData,
  output logic [NPORTS-1:0]             bankVld,
  output logic [NPORTS-1:0]             bankWe,
  output logic [NPORTS-1:0][ROW_W-1:0]  bankRow,
  output logic [NPORTS-1:0][DATA_W-1:0] bankWdata,
  input  logic [NPORTS-1:0][DATA_W-1:0] bankRdata
);
  netStrobe_t                strobe;
  logic [NPORTS-1:0][LG-1:0] reqBank;

  always_comb
    for (int p = 0; p < NPORTS; p++) reqBank[p] = reqAddr[p][LG-1:0];

  mnet_ctl i_ctl (
    .clk    (clk),
    .rst    (rst),
    .reqVld (reqVld),
    .reqBank(reqBank),
    .strobe (strobe),
    .ackQ   (reqAck),
    .nackQ  (reqNack)
  );

  mnet_dp i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .reqWe    (reqWe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .bankRdata(bankRdata),
    .bankVld  (bankVld),
    .bankWe   (bankWe),
    .bankRow  (bankRow),
    .bankWdata(bankWdata),
    .rspVld   (rspVld),
    .rspData  (rspData)
  );

  // R1
  bank_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(bankVld) == $countones(reqAck));
endmodule

// File: tb/test_mnet_top.sv
module test_mnet_top;
  import mnet_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPORTS-1:0]             vld, we;
  logic [NPORTS-1:0][ADDR_W-1:0] addr;
  logic [NPORTS-1:0][DATA_W-1:0] wd;
  logic [NPORTS-1:0]             ackO, nackO, rspVld, bankVld, bankWe;
  logic [NPORTS-1:0][DATA_W-1:0] rspData, bankWdata, bankRdata;
  logic [NPORTS-1:0][ROW_W-1:0]  bankRow;

  always #2 clk = ~clk;

  mnet_top i_mnet_top (
    .clk(clk), .rst(rst), .reqVld(vld), .reqWe(we), .reqAddr(addr), .reqWdata(wd),
    .reqAck(ackO), .reqNack(nackO), .rspVld(rspVld), .rspData(rspData),
    .bankVld(bankVld), .bankWe(bankWe), .bankRow(bankRow), .bankWdata(bankWdata),
    .bankRdata(bankRdata)
  );

  // single-cycle bank RAMs
  logic [DATA_W-1:0] bmem [NPORTS][1 << ROW_W];
  always @(posedge clk)
    for (int b = 0; b < NPORTS; b++)
      if (bankVld[b]) begin
        if (bankWe[b]) bmem[b][bankRow[b]] <= bankWdata[b];
        bankRdata[b] <= bmem[b][bankRow[b]];
      end

  logic [DATA_W-1:0] refMem [1 << ADDR_W];
  int nChk = 0, nFail = 0;
  logic [NPORTS-1:0]             lastVld, lastWe;
  logic [NPORTS-1:0][ADDR_W-1:0] lastAddr;
  logic [NPORTS-1:0][DATA_W-1:0] lastWd;
  logic [NPORTS-1:0]             s0v, s1v, s2v;
  logic [NPORTS-1:0][DATA_W-1:0] s0d, s1d, s2d;

  // entry: {we, xor constant[2:0], row[6:0]}
  localparam logic [10:0] VEC [16] = '{
    {1'b1, 3'd0, 7'd1}, {1'b1, 3'd1, 7'd2}, {1'b1, 3'd2, 7'd3}, {1'b1, 3'd3, 7'd4},
    {1'b1, 3'd4, 7'd5}, {1'b1, 3'd5, 7'd6}, {1'b1, 3'd6, 7'd7}, {1'b1, 3'd7, 7'd8},
    {1'b0, 3'd3, 7'd1}, {1'b0, 3'd5, 7'd2}, {1'b0, 3'd0, 7'd8}, {1'b0, 3'd6, 7'd4},
    {1'b0, 3'd1, 7'd7}, {1'b0, 3'd7, 7'd3}, {1'b0, 3'd2, 7'd5}, {1'b0, 3'd4, 7'd6}
  };
  localparam int OPS = 30;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic idle();
    vld = '0; we = '0;
  endtask

  // one clock; checks ack/nack and the reply pipeline
  task automatic tick();
    lastVld = vld; lastWe = we; lastAddr = addr; lastWd = wd;
    @(posedge clk);
    @(negedge clk);
    chk(((ackO | nackO) == lastVld) && ((ackO & nackO) == '0), "R4 ack/nack",
        {48'h0, ackO, nackO}, {56'h0, lastVld});
    s2v = s1v; s2d = s1d; s1v = s0v; s1d = s0d; s0v = '0;
    for (int p = 0; p < NPORTS; p++)
      if (ackO[p]) begin
        if (lastWe[p]) refMem[lastAddr[p]] = lastWd[p];
        else begin s0v[p] = 1'b1; s0d[p] = refMem[lastAddr[p]]; end
      end
    for (int p = 0; p < NPORTS; p++)
      chk((rspVld[p] == s2v[p]) && (!s2v[p] || rspData[p] == s2d[p]), "R3/R8 reply",
          {31'h0, rspVld[p], rspData[p]}, {31'h0, s2v[p], s2d[p]});
  endtask

  task automatic put(input int p, input bit w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    vld[p] = 1'b1; we[p] = w; addr[p] = a; wd[p] = d;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [NPORTS-1:0] w1, w2;
    int opIdx [NPORTS];
    int run [NPORTS];
    int maxRun, guard;
    bit busy;
    logic [31:0] x;
    for (int i = 0; i < (1 << ADDR_W); i++) refMem[i] = '0;
    for (int b = 0; b < NPORTS; b++)
      for (int r = 0; r < (1 << ROW_W); r++) bmem[b][r] = '0;
    s0v = '0; s1v = '0; s2v = '0; s0d = '0; s1d = '0; s2d = '0;
    addr = '0; wd = '0;
    idle();

    // R10: reset state
    repeat (3) @(negedge clk);
    chk({ackO, nackO, rspVld, bankVld} == '0, "R10 during reset", {32'h0, ackO, nackO, rspVld, bankVld}, 0);
    rst = 1'b0;
    tick();
    chk({ackO, nackO, rspVld, bankVld} == '0, "R10 after reset", {32'h0, ackO, nackO, rspVld, bankVld}, 0);

    // R11/R1: XOR permutations via the vector table
    for (int e = 0; e < 16; e++) begin
      for (int p = 0; p < NPORTS; p++)
        put(p, VEC[e][10], {VEC[e][6:0], 3'(p) ^ VEC[e][9:7]}, 32'hC0DE_0000 | (e << 8) | p);
      tick();
      chk(ackO == 8'hFF, "R11 permutation accepted", {56'h0, ackO}, 64'hFF);
      chk(bankVld == 8'hFF, "R1 all banks reached", {56'h0, bankVld}, 64'hFF);
    end
    idle();
    repeat (3) tick();

    // R2 bank decode, R7 write then read, R8 reply only to issuer
    put(3, 1'b1, {7'd9, 3'd5}, 32'h1234_ABCD);
    tick();
    chk(bankVld == 8'h20 && bankWe[5] && bankRow[5] == 7'd9 && bankWdata[5] == 32'h1234_ABCD,
        "R2 bank port", {24'h0, bankVld, bankRow[5], bankWdata[5]}, {24'h0, 8'h20, 7'd9, 32'h1234_ABCD});
    idle();
    tick();
    put(6, 1'b0, {7'd9, 3'd5}, '0);
    tick();
    chk(rspVld == '0, "R7 write gives no reply", {56'h0, rspVld}, 0);
    idle();
    tick();
    tick();
    chk(rspVld == 8'h40 && rspData[6] == 32'h1234_ABCD, "R7/R8 read back on issuing port",
        {24'h0, rspVld, rspData[6]}, {24'h0, 8'h40, 32'h1234_ABCD});

    // R5: same-address reads in one cycle are not merged
    put(0, 1'b0, {7'd1, 3'd0}, '0);
    put(1, 1'b0, {7'd1, 3'd0}, '0);
    tick();
    w1 = ackO;
    chk($countones(ackO) == 1 && $countones(nackO) == 1, "R5 one winner",
        {48'h0, ackO, nackO}, 64'h1);
    idle();
    tick();
    tick();
    chk(rspVld == w1, "R5 single reply", {56'h0, rspVld}, {56'h0, w1});

    // R6: back-to-back conflicts alternate (level 0 pair, then level 2 pair)
    put(0, 1'b0, {7'd2, 3'd0}, '0);
    put(1, 1'b0, {7'd3, 3'd0}, '0);
    tick(); w1 = ackO;
    tick(); w2 = ackO;
    chk($countones(w1) == 1 && $countones(w2) == 1 && w1 != w2, "R6 alternation level0",
        {48'h0, w1, w2}, 64'h0);
    idle();
    put(0, 1'b1, {7'd4, 3'd0}, 32'hAAAA_0000);
    put(4, 1'b1, {7'd5, 3'd0}, 32'hBBBB_0000);
    tick(); w1 = ackO;
    tick(); w2 = ackO;
    chk($countones(w1) == 1 && $countones(w2) == 1 && w1 != w2, "R6 alternation level2",
        {48'h0, w1, w2}, 64'h0);
    idle();
    repeat (3) tick();

    // R9: retry traffic on a small hot address set
    maxRun = 0; guard = 0;
    for (int p = 0; p < NPORTS; p++) begin opIdx[p] = 0; run[p] = 0; end
    busy = 1'b1;
    while (busy && guard < 5000) begin
      for (int p = 0; p < NPORTS; p++) begin
        if (opIdx[p] < OPS) begin
          x = 32'((p * 97 + opIdx[p] * 31 + 7) * 32'h9E37_79B1);
          put(p, x[27], ADDR_W'({x[17:16], x[30:28]}), x);
        end else vld[p] = 1'b0;
      end
      tick();
      busy = 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
        if (ackO[p]) begin opIdx[p]++; run[p] = 0; end
        else if (nackO[p]) begin run[p]++; if (run[p] > maxRun) maxRun = run[p]; end
        if (opIdx[p] < OPS) busy = 1'b1;
      end
      guard++;
    end
    idle();
    repeat (3) tick();
    for (int p = 0; p < NPORTS; p++)
      chk(opIdx[p] == OPS, "R9 all requests completed", opIdx[p], OPS);
    chk(maxRun < 32, "R6 no starvation", maxRun, 32);

    finishRun();
  end
endmodule